// File: doc/BRIEF.md
# Edge-Sensing Interrupt Flag Unit

This block watches twelve external request pins and turns each qualifying edge into a sticky pending flag. The pins fall into two groups. Four are dedicated request pins, and each of them only raises a flag while its function-select bit assigns it to interrupt use. Eight are shared with general-purpose port bits. Those raise flags whatever the port configuration is. Because each pin input carries the pad level, this includes edges that the chip itself drives out.

Every pin has its own polarity bit that chooses rising-edge or falling-edge sensing. The pins are asynchronous, so each one goes through a two-flop synchronizer. An edge is found by comparing the synchronized sample with the one held from the cycle before.

A small synchronous register port sets the polarity and function-select bits and reads back all state. Software clears a flag by writing 0 to its bit. The enable mask, priority and vector logic sit downstream and read the flag vector output.

Top module: `edge_flag_unit`

## Requirements
- R1: Flag vector bit i (0..3) belongs to dedicated pin i, and bit 4+j (0..7) belongs to shared pin j. An edge that matches the selected polarity sets that bit to 1. Polarity bit value 1 selects rising and 0 selects falling.
- R2: An edge of the opposite polarity leaves the flag unchanged.
- R3: A dedicated-pin edge sets its flag only while its function-select bit is 1 (interrupt use). While the bit is 0 (port use), the edge is ignored.
- R4: A shared-pin edge sets its flag for any configuration, and no function-select bit affects it.
- R5: A pin change made before rising clock edge k shows up on the flag output after edge k+2. This is two synchronizer flops plus one held sample.
- R6: A flag stays set until a write to address 2 carries 0 in its bit. A 1 in a written bit leaves that flag as it is.
- R7: When a qualifying edge and a clearing write fall on the same clock edge, the flag ends up set.
- R8: Changing a polarity bit while the pin is steady does not set a flag.
- R9: Reset (asynchronous, active low) clears every flag, every polarity bit (falling) and every function-select bit (port use), and sets the synchronizer stages to 0.
- R10: Register port: address 0 holds polarity bits 11:0, address 1 holds function-select bits 3:0, and address 2 holds the flags 11:0. Reads are combinational. Unused bits and address 3 read 0. A write takes effect from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ded_pin_i | input | 4 | Dedicated request pin levels |
| shr_pin_i | input | 8 | Shared pin levels (pad level, including driven outputs) |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for cfg_addr |
| flags_o | output | 12 | Pending flag vector |

## Verification
The two functions that can meet on one clock edge are a newly detected edge on a pin and a software write that clears the same pin's flag. The bench first sets a flag and then changes the pin again. It places the clearing write in the exact cycle in which the synchronized sample differs from the held one. A correct design shows the flag still set afterwards. The same collision is judged every cycle by the reference model and by a property on the internal edge vector.

// File: rtl/efu_pkg.sv
package efu_pkg;
    typedef enum logic [1:0] {
        REG_POL  = 2'd0,
        REG_FSEL = 2'd1,
        REG_FLAG = 2'd2,
        REG_RSVD = 2'd3
    } efu_reg_e;
endpackage

// File: rtl/efu_sync.sv
module efu_sync #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
        logic [W-1:0] prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin_i;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.sync;
    assign prev_o = st_q.prev;
endmodule

// File: rtl/efu_edge_det.sv
module efu_edge_det #(
    parameter int W = 12
) (
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] gate_i,
    output logic [W-1:0] hit_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic rise, fall;
        assign rise     = sync_i[i] & ~prev_i[i];
        assign fall     = ~sync_i[i] & prev_i[i];
        assign hit_o[i] = gate_i[i] & (pol_i[i] ? rise : fall);
    end
endmodule

// File: rtl/efu_cfg.sv
module efu_cfg
    import efu_pkg::*;
#(
    parameter int N_ALL  = 12,
    parameter int N_DED  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [N_ALL-1:0]  pol_o,
    output logic [N_DED-1:0]  fsel_o
);
    typedef struct packed {
        logic [N_ALL-1:0] pol;
        logic [N_DED-1:0] fsel;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            unique case (efu_reg_e'(addr_i))
                REG_POL:  st_d.pol  = wdata_i[N_ALL-1:0];
                REG_FSEL: st_d.fsel = wdata_i[N_DED-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pol_o  = st_q.pol;
    assign fsel_o = st_q.fsel;
endmodule

// File: rtl/edge_flag_unit.sv
module edge_flag_unit
    import efu_pkg::*;
#(
    parameter int N_DED  = 4,
    parameter int N_SHR  = 8,
    parameter int DATA_W = 16,
    localparam int N_ALL = N_DED + N_SHR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_DED-1:0]  ded_pin_i,
    input  logic [N_SHR-1:0]  shr_pin_i,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic [N_ALL-1:0]  flags_o
);
    typedef struct packed {
        logic [N_ALL-1:0] flags;
    } top_st_t;

    logic [N_ALL-1:0] sync, prev, pol, gate, hit;
    logic [N_DED-1:0] fsel;
    logic             clr_wr;
    top_st_t          st_d, st_q;

    efu_sync #(.W(N_ALL)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({shr_pin_i, ded_pin_i}),
        .sync_o (sync),
        .prev_o (prev)
    );

    efu_cfg #(.N_ALL(N_ALL), .N_DED(N_DED), .DATA_W(DATA_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .addr_i  (cfg_addr),
        .wdata_i (cfg_wdata),
        .pol_o   (pol),
        .fsel_o  (fsel)
    );

    // Shared group is never gated; dedicated group follows its select bits.
    assign gate = {{N_SHR{1'b1}}, fsel};

    efu_edge_det #(.W(N_ALL)) u_det (
        .sync_i (sync),
        .prev_i (prev),
        .pol_i  (pol),
        .gate_i (gate),
        .hit_o  (hit)
    );

    assign clr_wr = cfg_we && (efu_reg_e'(cfg_addr) == REG_FLAG);

    always_comb begin
        st_d = st_q;
        if (clr_wr) st_d.flags = st_q.flags & cfg_wdata[N_ALL-1:0];
        // Set term applied last so a same-cycle edge outranks the clear.
        st_d.flags = st_d.flags | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (efu_reg_e'(cfg_addr))
            REG_POL:  cfg_rdata[N_ALL-1:0] = pol;
            REG_FSEL: cfg_rdata[N_DED-1:0] = fsel;
            REG_FLAG: cfg_rdata[N_ALL-1:0] = st_q.flags;
            default:  cfg_rdata = '0;
        endcase
    end

    assign flags_o = st_q.flags;
endmodule

// File: rtl/efu_checker.sv
module efu_checker
    import efu_pkg::*;
#(
    parameter int N_DED  = 4,
    parameter int N_ALL  = 12,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [1:0]        cfg_addr,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic [N_ALL-1:0]  flags_i,
    input logic [N_ALL-1:0]  hit_i,
    input logic [N_ALL-1:0]  sync_i,
    input logic [N_ALL-1:0]  prev_i,
    input logic [N_DED-1:0]  fsel_i
);
    localparam logic [N_ALL-1:0] DED_MASK = N_ALL'((1 << N_DED) - 1);

    logic             clr_wr;
    logic [N_ALL-1:0] wmask, fsel_ext;
    assign clr_wr   = cfg_we && (cfg_addr == 2'd2);
    assign wmask    = cfg_wdata[N_ALL-1:0];
    assign fsel_ext = N_ALL'(fsel_i);

    // R6: without a clearing write no flag drops
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((flags_i & $past(flags_i)) == $past(flags_i)));

    // R6: a clearing write removes zero-bits unless an edge lands
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((flags_i & ~$past(hit_i) & ~$past(wmask)) == '0));

    // R1, R7: a detected edge always leaves its flag set
    a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i != '0) |=> ((flags_i & $past(hit_i)) == $past(hit_i)));

    // R3: dedicated flags only rise while selected for interrupt use
    a_r3_ded_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_i & ~$past(flags_i) & DED_MASK & ~$past(fsel_ext)) == '0));

    // R8: a new flag needs a change between synchronized samples
    a_r8_no_false_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_i & ~$past(flags_i) & ~$past(sync_i ^ prev_i)) == '0));

    // R9: reset holds all flags clear
    a_r9_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (flags_i == '0));
endmodule

bind edge_flag_unit efu_checker #(
    .N_DED (N_DED),
    .N_ALL (N_ALL),
    .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .flags_i   (flags_o),
    .hit_i     (hit),
    .sync_i    (sync),
    .prev_i    (prev),
    .fsel_i    (fsel)
);

// File: tb/tb_edge_flag_unit.sv
module tb_edge_flag_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ded_pin = '0;
    logic [7:0]  shr_pin = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [11:0] flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    edge_flag_unit dut (
        .clk(clk), .rst_n(rst_n), .ded_pin_i(ded_pin), .shr_pin_i(shr_pin),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .flags_o(flags)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: pin history list, polarity/select words, flags
    logic [11:0] m_hist [3];
    logic [11:0] m_pol, m_flags;
    logic [3:0]  m_fsel;

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [15:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return {4'h0, m_pol};
            2'd1: return {12'h0, m_fsel};
            2'd2: return {4'h0, m_flags};
            default: return 16'h0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_hist[k]) m_hist[k] = '0;
            m_pol = '0; m_fsel = '0; m_flags = '0;
        end else begin
            logic [11:0] nf;
            nf = m_flags;
            if (cfg_we && cfg_addr == 2'd2) nf = nf & cfg_wdata[11:0];
            for (int i = 0; i < 12; i++) begin
                bit newer, older, allowed;
                newer   = m_hist[1][i];
                older   = m_hist[2][i];
                allowed = (i >= 4) || m_fsel[i];
                if (allowed && newer != older && newer == m_pol[i]) nf[i] = 1'b1;
            end
            m_flags = nf;
            if (cfg_we && cfg_addr == 2'd0) m_pol  = cfg_wdata[11:0];
            if (cfg_we && cfg_addr == 2'd1) m_fsel = cfg_wdata[3:0];
            m_hist[2] = m_hist[1];
            m_hist[1] = m_hist[0];
            m_hist[0] = {shr_pin, ded_pin};
            #(CLK_PERIOD/4);
            if (!done) begin
                check("R1 model flags", {4'h0, flags}, {4'h0, m_flags});
                check("R10 model rdata", cfg_rdata, m_read(cfg_addr));
            end
        end
    end

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = 2'd2;
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cfg_addr = 2'd2;
        ticks(3);
        check("R9 flags after reset", {4'h0, flags}, 16'h0);
        rst_n = 1'b1;
        ticks(2);
        cfg_addr = 2'd0; #1;
        check("R9 polarity reset falling", cfg_rdata, 16'h0);
        cfg_addr = 2'd1; #1;
        check("R9 select reset port", cfg_rdata, 16'h0);
        cfg_addr = 2'd2;

        // R2: rising on shared pin 2 with falling polarity -> nothing
        shr_pin[2] = 1'b1;
        ticks(5);
        check("R2 opposite edge ignored", {4'h0, flags}, 16'h0);

        // R5, R4, R1: falling edge on shared pin 2 -> bit 6 after 3 edges
        shr_pin[2] = 1'b0;
        ticks(2);
        check("R5 not yet visible", {4'h0, flags}, 16'h0);
        ticks(1);
        check("R5 R4 flag after three edges", {4'h0, flags}, 16'h0040);

        // R3: dedicated pin 1 in port use ignores falling edge
        ded_pin[1] = 1'b1; ticks(4);
        ded_pin[1] = 1'b0; ticks(4);
        check("R3 port-use edge ignored", {4'h0, flags}, 16'h0040);
        wr(2'd1, 16'h0002);
        ded_pin[1] = 1'b1; ticks(4);
        ded_pin[1] = 1'b0; ticks(4);
        check("R3 interrupt-use edge sets", {4'h0, flags}, 16'h0042);

        // R1: rising polarity on shared pin 7 -> bit 11
        wr(2'd0, 16'h0800);
        shr_pin[7] = 1'b1; ticks(4);
        check("R1 rising polarity sets", {4'h0, flags}, 16'h0842);

        // R8: flip every polarity with pins steady
        wr(2'd0, 16'h0FFF); ticks(4);
        wr(2'd0, 16'h0000); ticks(4);
        check("R8 polarity change no flag", {4'h0, flags}, 16'h0842);

        // R6: clear bit 6 only; ones leave others
        wr(2'd2, 16'hFFBF);
        check("R6 write-zero clears", {4'h0, flags}, 16'h0802);
        wr(2'd2, 16'hFFFF);
        check("R6 write-one no effect", {4'h0, flags}, 16'h0802);

        // R10: readback and reserved address
        cfg_addr = 2'd1; #1;
        check("R10 select readback", cfg_rdata, 16'h0002);
        cfg_addr = 2'd3; #1;
        check("R10 reserved reads zero", cfg_rdata, 16'h0);
        cfg_addr = 2'd2;

        // R7: shared pin 0 falling edge collides with clear of bit 4
        shr_pin[0] = 1'b1; ticks(4);
        shr_pin[0] = 1'b0; ticks(4);
        check("R7 setup flag", {4'h0, flags}, 16'h0812);
        shr_pin[0] = 1'b1; ticks(4);
        shr_pin[0] = 1'b0;
        ticks(2);
        cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 16'hFFEF;
        ticks(1);
        cfg_we = 1'b0;
        check("R7 edge beats clear", {4'h0, flags}, 16'h0812);
        wr(2'd2, 16'hFFEF);
        check("R6 clear after collision", {4'h0, flags}, 16'h0802);

        // Mixed patterns driven together, judged by the model
        for (int n = 0; n < 40; n++) begin
            ded_pin = ded_pin ^ 4'(n * 5 + 3);
            shr_pin = shr_pin ^ 8'(n * 37 + 11);
            if (n % 7 == 3) wr(2'd0, 16'(n * 311));
            if (n % 9 == 4) wr(2'd1, 16'(n));
            if (n % 5 == 2) wr(2'd2, 16'(~(n * 97)));
            ticks(2);
        end
        ticks(4);

        // R9: reset mid-run clears flags
        rst_n = 1'b0; #1;
        check("R9 async reset clears", {4'h0, flags}, 16'h0);
        ded_pin = '0; shr_pin = '0;
        ticks(2);
        rst_n = 1'b1;
        ticks(3);
        finish_run();
    end
endmodule